// File: doc/BRIEF.md
# 64-bit Compare-Match Timer

This block is a memory-mapped timer built around a free-running 64-bit up-counter. A 4-bit prescaler sets how many input clocks pass between counter advances. A 64-bit comparator raises a sticky event flag once the count has reached or passed its value. An optional auto-increment value re-arms the comparator after each match, which gives periodic events. The flag, gated by an interrupt enable, drives one level-sensitive interrupt line.

Software reaches every register through a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. The 64-bit count and the 64-bit comparator each occupy two words. The count is read high word, then low word, then high word again. The counter supports this because its high word moves only on a carry out of the low word.

A three-state arming machine decides when a match may set the flag. The states are:
- `CMP_OFF`: the comparator is disabled.
- `CMP_ARMED`: a match can fire.
- `CMP_SPENT`: a single-shot match has already fired.

The transitions are:
- `OFF->ARMED` when comparator enable is set.
- `ARMED->OFF`, and `SPENT->OFF`, when comparator enable is cleared.
- `ARMED->SPENT` on a match with auto-increment off.
- `ARMED->ARMED` on a match with auto-increment on; the comparator advances by the auto-increment value.
- `SPENT->ARMED` when either comparator half is written.

Top module: `cmp_timer64`

## Requirements
- R1: After reset every register reads zero. The interrupt is low, and the count does not advance.
- R2: Register map by byte offset:
  - 0x00: count low.
  - 0x04: count high.
  - 0x08: control.
  - 0x0C: status.
  - 0x10: comparator low.
  - 0x14: comparator high.
  - 0x18: auto-increment.

  Any other offset reads zero. Control reads back only bits 0-3 and 11:8; all its other bits read zero.
- R3: Control bit 0 runs the counter. Both count halves are writable while it is stopped. With the bit clear the count holds its value.
- R4: Control bits 11:8 hold a prescaler P. While running, the count advances by exactly one every P+1 clocks.
- R5: The high count word changes only when the low word wraps from all-ones to zero, unless software writes it.
- R6: With comparator enable (control bit 1) set, the event flag (status bit 0) sets once the 64-bit count is greater than or equal to the 64-bit comparator. It also sets when the count is already past the comparator when the comparator is enabled.
- R7: With comparator enable clear, the event flag never sets, whatever the count and comparator values.
- R8: The event flag stays set until software writes status with bit 0 = 1. A status write with bit 0 = 0 leaves the flag unchanged.
- R9: The interrupt output equals the event flag ANDed with interrupt enable (control bit 2).
- R10: With auto-increment (control bit 3) set, each match adds the auto-increment register to the comparator. The next event therefore comes that many counts later.
- R11: With auto-increment clear, a match fires once. The flag does not set again until a comparator half is written or comparator enable is cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt: event flag AND interrupt enable |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 64-bit count and a 4-bit prescaler. These bring divide-by-1, divide-by-4 and divide-by-16 within reach. Counter writability lets the bench preload the count just below a low-word wrap, so the carry into the high word is seen within a few clocks. It also lets the bench build comparisons that only the high word decides. The arming machine is driven through every transition: single-shot fire and silence, re-arm by rewrite and by enable toggle, and two auto-increment periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int OFS_CNT_LO  = 'h00;
    localparam int OFS_CNT_HI  = 'h04;
    localparam int OFS_CTRL    = 'h08;
    localparam int OFS_STAT    = 'h0C;
    localparam int OFS_CMP_LO  = 'h10;
    localparam int OFS_CMP_HI  = 'h14;
    localparam int OFS_AINC    = 'h18;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_CMP    = 1;
    localparam int CTRL_IRQ    = 2;
    localparam int CTRL_AINC   = 3;
    localparam int CTRL_PS_LSB = 8;

    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_ARMED = 2'd1,
        CMP_SPENT = 2'd2
    } cmp_state_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps_val,
    output logic            tick
);
    logic [PS_W-1:0] div_q;

    assign tick = run && (div_q == ps_val);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    // R4: with a nonzero prescaler two ticks are never adjacent
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps_val != '0) |=> (!tick || ps_val == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt[CNT_W-1:DATA_W] <= wdata;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R5: an unwritten high word moves only as the low word wraps to zero
    p_carry_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cnt[CNT_W-1:DATA_W]) && !$past(wr_lo || wr_hi))
        |-> (cnt[DATA_W-1:0] == '0));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cmp_en,
    input  logic              ainc_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_ainc,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [DATA_W-1:0] ainc_val,
    output logic              hit
);
    cmp_state_t state_q, state_d;
    logic       reached;
    logic       cmp_wr;

    assign reached = (cnt >= cmp_val);
    assign cmp_wr  = wr_lo || wr_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMP_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_OFF:   if (cmp_en) state_d = CMP_ARMED;
            CMP_ARMED: begin
                if (!cmp_en)                    state_d = CMP_OFF;
                else if (reached && !ainc_en)   state_d = CMP_SPENT;
            end
            CMP_SPENT: begin
                if (!cmp_en)     state_d = CMP_OFF;
                else if (cmp_wr) state_d = CMP_ARMED;
            end
            default:   state_d = CMP_OFF;
        endcase
    end

    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            CMP_ARMED: hit = cmp_en && reached;
            CMP_OFF, CMP_SPENT: hit = 1'b0;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val  <= '0;
            ainc_val <= '0;
        end else begin
            if (wr_ainc) ainc_val <= wdata;
            if (cmp_wr) begin
                if (wr_lo) cmp_val[DATA_W-1:0]     <= wdata;
                if (wr_hi) cmp_val[CNT_W-1:DATA_W] <= wdata;
            end else if (hit && ainc_en) begin
                cmp_val <= cmp_val + CNT_W'(ainc_val);
            end
        end
    end

    // R11: a single-shot match is never followed by another match next cycle
    p_single_shot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ainc_en) |=> !hit);
    // R10: a periodic match advances the comparator by the step
    p_ainc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ainc_en && !cmp_wr) |=> (cmp_val == $past(cmp_val + CNT_W'(ainc_val))));
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int PS_W   = 4,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic            run_en, cmp_en, irq_en, ainc_en, flag_q;
    logic [PS_W-1:0] ps_val;
    logic            tick, hit;
    logic [CNT_W-1:0]  cnt, cmp_val;
    logic [DATA_W-1:0] ainc_val;

    logic we_cnt_lo, we_cnt_hi, we_ctrl, we_stat, we_cmp_lo, we_cmp_hi, we_ainc;
    assign we_cnt_lo = bus_we && (bus_addr == ADDR_W'(OFS_CNT_LO));
    assign we_cnt_hi = bus_we && (bus_addr == ADDR_W'(OFS_CNT_HI));
    assign we_ctrl   = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign we_stat   = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
    assign we_cmp_lo = bus_we && (bus_addr == ADDR_W'(OFS_CMP_LO));
    assign we_cmp_hi = bus_we && (bus_addr == ADDR_W'(OFS_CMP_HI));
    assign we_ainc   = bus_we && (bus_addr == ADDR_W'(OFS_AINC));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {run_en, cmp_en, irq_en, ainc_en} <= '0;
            ps_val <= '0;
        end else if (we_ctrl) begin
            run_en  <= bus_wdata[CTRL_RUN];
            cmp_en  <= bus_wdata[CTRL_CMP];
            irq_en  <= bus_wdata[CTRL_IRQ];
            ainc_en <= bus_wdata[CTRL_AINC];
            ps_val  <= bus_wdata[CTRL_PS_LSB +: PS_W];
        end
    end

    // set beats clear so an event landing on a clear write is kept
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (hit)                    flag_q <= 1'b1;
        else if (we_stat && bus_wdata[0]) flag_q <= 1'b0;
    end

    assign irq = flag_q && irq_en;

    tmr_prescaler #(.PS_W(PS_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .run(run_en), .ps_val(ps_val), .tick(tick)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(we_cnt_lo),
        .wr_hi(we_cnt_hi), .wdata(bus_wdata), .cnt(cnt)
    );

    tmr_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_en(cmp_en), .ainc_en(ainc_en),
        .wr_lo(we_cmp_lo), .wr_hi(we_cmp_hi), .wr_ainc(we_ainc),
        .wdata(bus_wdata), .cmp_val(cmp_val), .ainc_val(ainc_val), .hit(hit)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CNT_LO): bus_rdata = cnt[DATA_W-1:0];
            ADDR_W'(OFS_CNT_HI): bus_rdata = cnt[CNT_W-1:DATA_W];
            ADDR_W'(OFS_CTRL):   bus_rdata = DATA_W'({ps_val, 4'b0000, ainc_en, irq_en, cmp_en, run_en});
            ADDR_W'(OFS_STAT):   bus_rdata = DATA_W'(flag_q);
            ADDR_W'(OFS_CMP_LO): bus_rdata = cmp_val[DATA_W-1:0];
            ADDR_W'(OFS_CMP_HI): bus_rdata = cmp_val[CNT_W-1:DATA_W];
            ADDR_W'(OFS_AINC):   bus_rdata = ainc_val;
            default:             bus_rdata = '0;
        endcase
    end

    // R7: the flag can only rise after a cycle with the comparator enabled
    p_flag_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cmp_en));
    // R8: without a clearing write the flag holds
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(we_stat && bus_wdata[0])) |=> flag_q);
endmodule

// File: tb/tb_cmp_timer64.sv
module tb_cmp_timer64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cmp_timer64 dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08,
        A_ST = 5'h0C, A_MLO = 5'h10, A_MHI = 5'h14, A_INC = 5'h18;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_flag(input int lim, output bit got);
        logic [31:0] v;
        got = 1'b0;
        for (int i = 0; i < lim && !got; i++) begin
            rd(A_ST, v);
            got = v[0];
        end
    endtask

    task automatic setup(input logic [63:0] c, input logic [63:0] m);
        wr(A_CTL, 32'h0);
        wr(A_CLO, c[31:0]); wr(A_CHI, c[63:32]);
        wr(A_MLO, m[31:0]); wr(A_MHI, m[63:32]);
        wr(A_ST, 32'h1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            chk("R1 reset read", v, 0);
        end
        repeat (5) @(negedge clk);
        rd(A_CLO, v); chk("R1 count idle", v, 0);
        chk("R1 irq low", irq, 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(A_CTL, 32'hFFFF_F0F0);
        rd(A_CTL, v); chk("R2 ctrl ignored bits", v, 0);
        wr(A_CTL, 32'h0000_0A04);
        rd(A_CTL, v); chk("R2 ctrl readback", v, 32'h0A04);
        wr(A_INC, 32'h1234_5678);
        rd(A_INC, v); chk("R2 ainc readback", v, 32'h1234_5678);
        rd(5'h1C, v); chk("R2 unmapped zero", v, 0);
        wr(A_CTL, 32'h0);
        wr(A_INC, 32'h0);
    endtask

    task automatic t_run_stop;
        logic [31:0] a, b;
        setup(64'h0000_0007_0000_0100, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_CLO, a); chk("R3 load low", a, 32'h100);
        rd(A_CHI, a); chk("R3 load high", a, 7);
        repeat (10) @(negedge clk);
        rd(A_CLO, a); chk("R3 stopped holds", a, 32'h100);
        wr(A_CTL, 32'h1);
        repeat (10) @(negedge clk);
        wr(A_CTL, 32'h0);
        rd(A_CLO, a);
        repeat (10) @(negedge clk);
        rd(A_CLO, b);
        chk("R3 ran then holds", {31'b0, a > 32'h100}, 1);
        chk("R3 hold after stop", b, a);
    endtask

    task automatic t_presc(input int p, input int n);
        logic [31:0] a, b;
        setup(64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(A_CTL, 32'h1 | (32'(p) << 8));
        rd(A_CLO, a);
        repeat (n * (p + 1) - 1) @(negedge clk);
        rd(A_CLO, b);
        chk($sformatf("R4 presc %0d", p), b - a, 32'(n));
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_carry;
        logic [31:0] lo, hi;
        bit seen_wrap = 1'b0;
        setup(64'h0000_0005_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_CHI, hi); chk("R5 high before", hi, 5);
        wr(A_CTL, 32'h3 << 8 | 32'h1);
        for (int i = 0; i < 30; i++) begin
            rd(A_CLO, lo);
            #1 hi = bus_rdata;
            bus_addr = A_CHI;
            #1 hi = bus_rdata;
            if (lo >= 32'hFFFF_FFFD) chk("R5 high pre-wrap", hi, 5);
            else begin
                chk("R5 high post-wrap", hi, 6);
                seen_wrap = 1'b1;
            end
        end
        chk("R5 wrap seen", seen_wrap, 1);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_ge;
        logic [31:0] v;
        setup(64'd1000, {32'd1, 32'd500});
        wr(A_CTL, 32'h2);
        repeat (10) @(negedge clk);
        rd(A_ST, v); chk("R6 high word decides no match", v, 0);
        wr(A_CHI, 32'd1);
        repeat (3) @(negedge clk);
        rd(A_ST, v); chk("R6 count past comparator matches", v, 1);
        chk("R9 irq gated off", irq, 0);
        wr(A_CTL, 32'h6);
        chk("R9 irq on enable", irq, 1);
        wr(A_ST, 32'h0);
        rd(A_ST, v); chk("R8 write 0 keeps flag", v, 1);
        wr(A_ST, 32'h1);
        rd(A_ST, v); chk("R8 write 1 clears", v, 0);
        chk("R9 irq after clear", irq, 0);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_cmp_off;
        logic [31:0] v;
        setup(64'd0, 64'd5);
        wr(A_CTL, 32'h5);
        repeat (30) @(negedge clk);
        rd(A_ST, v); chk("R7 disabled no flag", v, 0);
        chk("R7 irq stays low", irq, 0);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_oneshot;
        logic [31:0] v;
        bit got;
        setup(64'd0, 64'd10);
        wr(A_CTL, 32'h7);
        wait_flag(40, got);
        chk("R6 timed match", got, 1);
        chk("R9 irq with flag", irq, 1);
        wr(A_ST, 32'h1);
        repeat (30) @(negedge clk);
        rd(A_ST, v); chk("R11 no second event", v, 0);
        wr(A_MHI, 32'h0);
        repeat (3) @(negedge clk);
        rd(A_ST, v); chk("R11 rearm by rewrite", v, 1);
        wr(A_ST, 32'h1);
        repeat (10) @(negedge clk);
        rd(A_ST, v); chk("R11 quiet after rearm fire", v, 0);
        wr(A_CTL, 32'h5);
        wr(A_CTL, 32'h7);
        repeat (3) @(negedge clk);
        rd(A_ST, v); chk("R11 rearm by toggle", v, 1);
        wr(A_CTL, 32'h0);
        wr(A_ST, 32'h1);
    endtask

    task automatic t_periodic;
        logic [31:0] v;
        bit got;
        setup(64'd0, 64'd20);
        wr(A_INC, 32'd50);
        wr(A_CTL, 32'hB);
        wait_flag(60, got);
        chk("R10 first event", got, 1);
        rd(A_MLO, v); chk("R10 comparator +1 step", v, 70);
        wr(A_ST, 32'h1);
        wait_flag(80, got);
        chk("R10 second event", got, 1);
        rd(A_MLO, v); chk("R10 comparator +2 steps", v, 120);
        rd(A_CLO, v); chk("R10 count near period", {31'b0, v >= 70 && v < 80}, 1);
        wr(A_CTL, 32'h0);
        wr(A_ST, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_run_stop();
        t_presc(0, 16);
        t_presc(3, 10);
        t_presc(15, 4);
        t_carry();
        t_ge();
        t_cmp_off();
        t_oneshot();
        t_periodic();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule